// File: doc/BRIEF.md
# Interrupt Source Conditioning Unit

This block sits between a bank of external interrupt lines and the logic that routes interrupts to processors. For every line it keeps a small configuration: whether the line is active high or active low, whether it is sensed as a level or as an edge, whether an edge line fires on both transitions, and whether the line is enabled. It resynchronises each raw line into the local clock domain, captures edge events in a sticky per-line latch, and produces a per-line pending vector. That vector is both driven on a port and readable through the register port.

Software reaches the configuration through a plain 32-bit register port. Enables never change through a read-modify-write. One write-one-to-set port and one write-one-to-clear port change them, and a read-only bank shows the result. A single command word can inject an edge event on a chosen line, or remove one. This is the only way to retire a latched edge other than reset. The register port has no flow control: a write completes in the cycle it is presented. Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read.

Top module: `irq_cond_unit`

## Requirements
- R1: After reset every polarity, trigger, dual-edge, enable and edge-latch bit is 0, `pend_o` is all zero and every register reads 0.
- R2: The polarity, trigger and dual-edge banks at byte offsets 0x100, 0x180 and 0x200 are read/write. Line n sits in word n/32 (offset + 4*(n/32)), bit n%32. Read data appears on `rdata` the cycle after `rd_en`. Words past NUM_IRQ/32 read 0 and ignore writes.
- R3: A line with trigger 0 is level sensed. Its qualified level is the synchronised input when polarity is 1, and the inverted input when polarity is 0. It is pending while it is enabled and the qualified level is 1, with no latching.
- R4: A line with trigger 1 and dual-edge 0 sets its edge latch on a rising input transition when polarity is 1, and on a falling one when polarity is 0. The latch stays set after the input returns.
- R5: A line with trigger 1 and dual-edge 1 sets its edge latch on either transition. The dual-edge bit has no effect on a level-sensed line.
- R6: Writing offset 0x380 sets the enable of each line whose data bit is 1. Writing 0x300 clears the enable of each such line. Zero data bits leave enables unchanged. The enables are read at 0x400, where a 1 means enabled.
- R7: A write to 0x280 with bit 31 = 1 sets the edge latch of the line numbered by bits 30:0. With bit 31 = 0 the same write clears that latch. A line number of NUM_IRQ or more leaves every latch unchanged.
- R8: A line is pending exactly when it is enabled and either (trigger 1 and its latch is set) or (trigger 0 and its qualified level is 1). Pending is shown on `pend_o` and read at 0x480. A latch survives disabling and is cleared only by the command or by reset.
- R9: The write-only words at 0x280, 0x300 and 0x380 read 0. Writes to the read-only banks at 0x400 and 0x480 change nothing. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Raw asynchronous interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| pend_o | output | NUM_IRQ | Per-line pending vector |

## Verification
The bench goes after the polarity and edge-direction pairing. A design that mixes them up latches a falling edge on an active-high line and leaves `pend_o` set where it must stay clear. Dual-edge lines are hit on the second transition after a clear, and dual-edge is also set on level lines. A wrong design would miss the second edge, or would start latching a level line that should follow its input. Command writes with an out-of-range line number that aliases a live line in its low bits are included. A design that only decodes the low bits would wipe that line's latch. The bench also disables and re-enables a latched line, which exposes a design that clears latches on disable, and it writes the read-only banks, which exposes a decoder that lets those writes land.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned CMD_SET = 31;

  typedef enum logic [4:0] {
    BK_POL   = 5'd2,
    BK_TRIG  = 5'd3,
    BK_DUAL  = 5'd4,
    BK_CMD   = 5'd5,
    BK_CLRM  = 5'd6,
    BK_SETM  = 5'd7,
    BK_MASK  = 5'd8,
    BK_PEND  = 5'd9
  } bank_e;

endpackage

// File: rtl/irq_cond_sync.sv
module irq_cond_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] stg1;
  logic [WIDTH-1:0] stg2;
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1 <= '0;
      stg2 <= '0;
      prev <= '0;
    end else begin
      stg1 <= raw;
      stg2 <= stg1;
      prev <= stg2;
    end
  end

  assign lvl  = stg2;
  assign rise = stg2 & ~prev;
  assign fall = ~stg2 & prev;

endmodule

// File: rtl/irq_cond_lines.sv
module irq_cond_lines #(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pol,
  input  logic [NUM_IRQ-1:0] trig,
  input  logic [NUM_IRQ-1:0] dual,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] lvl,
  input  logic [NUM_IRQ-1:0] rise,
  input  logic [NUM_IRQ-1:0] fall,
  input  logic [NUM_IRQ-1:0] cmd_set,
  input  logic [NUM_IRQ-1:0] cmd_clr,
  output logic [NUM_IRQ-1:0] latch_q,
  output logic [NUM_IRQ-1:0] pend
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic act_lvl;
    logic hw_hit;
    logic nxt;

    assign act_lvl = pol[i] ? lvl[i] : ~lvl[i];

    // Hardware edge per trigger mode; dual-edge overrides direction.
    always_comb begin
      hw_hit = 1'b0;
      if (trig[i]) begin
        if (dual[i]) hw_hit = rise[i] | fall[i];
        else         hw_hit = pol[i] ? rise[i] : fall[i];
      end
    end

    // A hardware edge in the same cycle as a clear command wins.
    assign nxt = hw_hit | cmd_set[i] | (latch_q[i] & ~cmd_clr[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) latch_q[i] <= 1'b0;
      else        latch_q[i] <= nxt;
    end

    assign pend[i] = mask[i] & (trig[i] ? latch_q[i] : act_lvl);
  end

endmodule

// File: rtl/irq_cond_regs.sv
module irq_cond_regs
  import irq_cond_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_IRQ-1:0] pend,
  output logic [REG_W-1:0]   rdata,
  output logic [NUM_IRQ-1:0] pol_q,
  output logic [NUM_IRQ-1:0] trig_q,
  output logic [NUM_IRQ-1:0] dual_q,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic [NUM_IRQ-1:0] cmd_set,
  output logic [NUM_IRQ-1:0] cmd_clr
);

  localparam int unsigned NWORDS = NUM_IRQ / REG_W;
  localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  bank_e            bank;
  logic [4:0]       word;
  logic             word_ok;
  logic             adr_lo_ok;
  logic [REG_W-1:0] rd_word;

  assign bank      = bank_e'(addr[11:7]);
  assign word      = addr[6:2];
  assign word_ok   = ({27'd0, word} < NWORDS);
  assign adr_lo_ok = (addr[1:0] == 2'b00);

  function automatic logic [REG_W-1:0] pick(input logic [NUM_IRQ-1:0] vec,
                                           input logic [4:0] w);
    logic [REG_W-1:0] r;
    r = '0;
    for (int k = 0; k < NWORDS; k++)
      if (w == 5'(k)) r = vec[k*REG_W +: REG_W];
    return r;
  endfunction

  // Configuration and enable banks.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trig_q <= '0;
      dual_q <= '0;
      mask_q <= '0;
    end else if (wr_en && word_ok && adr_lo_ok) begin
      for (int k = 0; k < NWORDS; k++) begin
        if (word == 5'(k)) begin
          case (bank)
            BK_POL:  pol_q[k*REG_W +: REG_W]  <= wdata;
            BK_TRIG: trig_q[k*REG_W +: REG_W] <= wdata;
            BK_DUAL: dual_q[k*REG_W +: REG_W] <= wdata;
            BK_SETM: mask_q[k*REG_W +: REG_W] <= mask_q[k*REG_W +: REG_W] | wdata;
            BK_CLRM: mask_q[k*REG_W +: REG_W] <= mask_q[k*REG_W +: REG_W] & ~wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // Edge command: one word, line number in 30:0, set/clear flag on top.
  always_comb begin
    cmd_set = '0;
    cmd_clr = '0;
    if (wr_en && bank == BK_CMD && word == 5'd0 && adr_lo_ok &&
        ({1'b0, wdata[CMD_SET-1:0]} < NUM_IRQ)) begin
      if (wdata[CMD_SET]) cmd_set[wdata[IDX_W-1:0]] = 1'b1;
      else                cmd_clr[wdata[IDX_W-1:0]] = 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    if (word_ok && adr_lo_ok) begin
      case (bank)
        BK_POL:  rd_word = pick(pol_q, word);
        BK_TRIG: rd_word = pick(trig_q, word);
        BK_DUAL: rd_word = pick(dual_q, word);
        BK_MASK: rd_word = pick(mask_q, word);
        BK_PEND: rd_word = pick(pend, word);
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

endmodule

// File: rtl/irq_cond_unit.sv
module irq_cond_unit
  import irq_cond_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic [NUM_IRQ-1:0] pend_o
);

  logic [NUM_IRQ-1:0] lvl, rise, fall;
  logic [NUM_IRQ-1:0] pol_q, trig_q, dual_q, mask_q;
  logic [NUM_IRQ-1:0] cmd_set, cmd_clr, latch_q;

  irq_cond_sync #(.WIDTH(NUM_IRQ)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (irq_in),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  irq_cond_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .pend   (pend_o),
    .rdata  (rdata),
    .pol_q  (pol_q),
    .trig_q (trig_q),
    .dual_q (dual_q),
    .mask_q (mask_q),
    .cmd_set(cmd_set),
    .cmd_clr(cmd_clr)
  );

  irq_cond_lines #(.NUM_IRQ(NUM_IRQ)) u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .pol    (pol_q),
    .trig   (trig_q),
    .dual   (dual_q),
    .mask   (mask_q),
    .lvl    (lvl),
    .rise   (rise),
    .fall   (fall),
    .cmd_set(cmd_set),
    .cmd_clr(cmd_clr),
    .latch_q(latch_q),
    .pend   (pend_o)
  );

endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk #(
  parameter int unsigned NUM_IRQ = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [11:0]        addr,
  input logic [31:0]        wdata,
  input logic [31:0]        rdata,
  input logic [NUM_IRQ-1:0] mask_q,
  input logic [NUM_IRQ-1:0] latch_q
);

  logic wo_rd;
  assign wo_rd = rd_en && (addr == 12'h280 || addr == 12'h300 || addr == 12'h380);

  // R6: a set-enable write leaves every written 1 enabled.
  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 12'h380) |-> ((mask_q[31:0] & $past(wdata)) == $past(wdata)));

  // R6: a clear-enable write leaves every written 1 disabled.
  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 12'h300) |-> ((mask_q[31:0] & $past(wdata)) == 32'd0));

  // R6: enables move only on a register write.
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(mask_q));

  // R8: a latch falls only after a clear command.
  p_latch_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && addr == 12'h280 && !wdata[31]) |-> (($past(latch_q) & ~latch_q) == '0));

  // R7: a set command for line 0 leaves its latch set.
  p_cmd_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 12'h280 && wdata == 32'h8000_0000) |-> latch_q[0]);

  // R9: write-only words read back as zero.
  p_wo_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wo_rd) |-> (rdata == 32'd0));

endmodule

bind irq_cond_unit irq_cond_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .mask_q (mask_q),
  .latch_q(latch_q)
);

// File: tb/test_irq_cond_unit.sv
`timescale 1ns/1ps
module test_irq_cond_unit;

  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pend_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [N-1:0] m_pol = '0, m_trig = '0, m_dual = '0, m_mask = '0, m_lat = '0, m_pin = '0;

  always #2 clk = ~clk;

  irq_cond_unit #(.NUM_IRQ(N)) i_irq_cond_unit (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pend_o(pend_o)
  );

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] lv;
    lv = ~(m_pin ^ m_pol);
    return m_mask & ((m_trig & m_lat) | (~m_trig & lv));
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [4:0] b;
    int w;
    logic [N-1:0] v;
    b = a[11:7];
    w = int'(a[6:2]);
    if (a[1:0] != 2'b00 || w >= N / 32) return 32'd0;
    case (b)
      5'd2: v = m_pol;
      5'd3: v = m_trig;
      5'd4: v = m_dual;
      5'd8: v = m_mask;
      5'd9: v = exp_pend();
      default: return 32'd0;
    endcase
    return v[w*32 +: 32];
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic m_write(input logic [11:0] a, input logic [31:0] d);
    int w;
    w = int'(a[6:2]);
    if (a[1:0] != 2'b00) return;
    if (a == 12'h280) begin
      if (d[30:0] < 31'(N)) m_lat[d[5:0]] = d[31];
      return;
    end
    if (w >= N / 32) return;
    case (a[11:7])
      5'd2: m_pol[w*32 +: 32] = d;
      5'd3: m_trig[w*32 +: 32] = d;
      5'd4: m_dual[w*32 +: 32] = d;
      5'd7: m_mask[w*32 +: 32] = m_mask[w*32 +: 32] | d;
      5'd6: m_mask[w*32 +: 32] = m_mask[w*32 +: 32] & ~d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pins(input logic [N-1:0] v);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (v[i] != m_pin[i] && m_trig[i]) begin
        if (m_dual[i] || (m_pol[i] == v[i])) m_lat[i] = 1'b1;
      end
    end
    irq_in = v;
    m_pin = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, {32'd0, d}, {32'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 pend_o", pend_o, '0);
    rd_chk("R1 enable bank", 12'h400, 32'd0);
    rd_chk("R1 polarity bank", 12'h100, 32'd0);
    rd_chk("R1 latch via trigger+enable", 12'h480, 32'd0);

    // R2 read/write banks, out-of-range word
    wr(12'h104, 32'hA5A5_0001);
    rd_chk("R2 polarity word1", 12'h104, 32'hA5A5_0001);
    wr(12'h204, 32'h0000_1000);
    rd_chk("R2 dual word1", 12'h204, 32'h0000_1000);
    wr(12'h208, 32'hFFFF_FFFF);
    rd_chk("R2 word past range", 12'h208, 32'd0);

    // R6 set / clear enables
    wr(12'h380, 32'h0000_00F0);
    rd_chk("R6 set enables", 12'h400, 32'h0000_00F0);
    wr(12'h380, 32'h0000_0003);
    rd_chk("R6 set keeps zeros", 12'h400, 32'h0000_00F3);
    wr(12'h300, 32'h0000_0010);
    rd_chk("R6 clear enables", 12'h400, 32'h0000_00E3);

    // R9 write-only / read-only / unmapped
    rd_chk("R9 set port reads 0", 12'h380, 32'd0);
    rd_chk("R9 cmd port reads 0", 12'h280, 32'd0);
    wr(12'h400, 32'hFFFF_FFFF);
    rd_chk("R9 enable bank ignores write", 12'h400, 32'h0000_00E3);
    rd_chk("R9 unmapped reads 0", 12'h600, 32'd0);

    // R3 level lines: pol 0, pins low -> active
    repeat (3) @(negedge clk);
    chk("R3 active-low level pending", {56'd0, pend_o[7:0]}, 64'h00E3);
    wr(12'h100, 32'h0000_0020);
    repeat (2) @(negedge clk);
    chk("R3 active-high idle", {63'd0, pend_o[5]}, 64'd0);
    pins(m_pin | 64'h20);
    chk("R3 active-high asserted", {63'd0, pend_o[5]}, 64'd1);

    // R4 edge rising on line 6
    wr(12'h100, 32'h0000_0060);
    wr(12'h180, 32'h0000_0040);
    repeat (2) @(negedge clk);
    chk("R4 edge line idle", {63'd0, pend_o[6]}, 64'd0);
    pins(m_pin | 64'h40);
    chk("R4 rising latched", {63'd0, pend_o[6]}, 64'd1);
    pins(m_pin & ~64'h40);
    chk("R8 latch held after input drops", {63'd0, pend_o[6]}, 64'd1);
    wr(12'h280, 32'h0000_0006);
    @(negedge clk);
    chk("R7 clear command", {63'd0, pend_o[6]}, 64'd0);

    // R4 falling on line 7 (pol 0)
    wr(12'h180, 32'h0000_00C0);
    pins(m_pin | 64'h80);
    chk("R4 pol0 ignores rise", {63'd0, pend_o[7]}, 64'd0);
    pins(m_pin & ~64'h80);
    chk("R4 pol0 latches fall", {63'd0, pend_o[7]}, 64'd1);

    // R5 dual on line 1
    wr(12'h180, 32'h0000_00C2);
    wr(12'h200, 32'h0000_0002);
    pins(m_pin | 64'h2);
    chk("R5 dual rise", {63'd0, pend_o[1]}, 64'd1);
    wr(12'h280, 32'h0000_0001);
    @(negedge clk);
    chk("R7 clear dual line", {63'd0, pend_o[1]}, 64'd0);
    pins(m_pin & ~64'h2);
    chk("R5 dual fall", {63'd0, pend_o[1]}, 64'd1);

    // R5 dual ignored on level line 0
    wr(12'h200, 32'h0000_0003);
    pins(m_pin | 64'h1);
    chk("R5 dual no effect on level", {63'd0, pend_o[0]}, 64'd0);

    // R7 command set on line 2, out-of-range alias
    wr(12'h180, 32'h0000_00C6);
    wr(12'h380, 32'h0000_0004);
    @(negedge clk);
    chk("R7 line2 idle", {63'd0, pend_o[2]}, 64'd0);
    wr(12'h280, 32'h8000_0002);
    @(negedge clk);
    chk("R7 set command", {63'd0, pend_o[2]}, 64'd1);
    wr(12'h280, 32'h0000_0042);
    @(negedge clk);
    chk("R7 out-of-range ignored", {63'd0, pend_o[2]}, 64'd1);

    // R8 latch survives disable
    wr(12'h300, 32'h0000_0004);
    @(negedge clk);
    chk("R8 disabled not pending", {63'd0, pend_o[2]}, 64'd0);
    wr(12'h380, 32'h0000_0004);
    @(negedge clk);
    chk("R8 re-enabled keeps latch", {63'd0, pend_o[2]}, 64'd1);
    rd_chk("R8 pending bank", 12'h480, exp_read(12'h480));
    chk("R8 directed model match", pend_o, exp_pend());

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [11:0] a;
      op = int'($urandom % 6);
      case (op)
        0: pins(m_pin ^ ({$urandom, $urandom} & {$urandom, $urandom}));
        1: begin
          a = 12'h100 + 12'(($urandom % 3) * 12'h80) + 12'(($urandom % 3) * 4);
          wr(a, $urandom);
        end
        2: wr(12'h380 + 12'(($urandom % 2) * 4), $urandom & $urandom);
        3: wr(12'h300 + 12'(($urandom % 2) * 4), $urandom & $urandom);
        4: wr(12'h280, {1'($urandom), 31'($urandom % 80)});
        default: begin
          a = 12'h100 + 12'(($urandom % 9) * 12'h80) + 12'(($urandom % 3) * 4);
          repeat (2) @(negedge clk);
          rd_chk("R2/R6/R9 random read", a, exp_read(a));
        end
      endcase
      repeat (2) @(negedge clk);
      chk("R8 random pending", pend_o, exp_pend());
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule